// File: doc/BRIEF.md
# CAN Bit Timing and Sampling Unit

This block produces the bit-level timing for a CAN-style serial receiver. A prescaler divides the module clock into time quanta. Each nominal bit is built from quanta: one synchronisation quantum, a first phase segment and a second phase segment. The receive line is sampled where the first segment ends. Sampling uses either the single value at that point or a two-of-three majority of the values taken at the last three quantum boundaries.

Falling (recessive-to-dominant) edges on the line keep the receiver locked to the transmitter. An edge seen after the synchronisation quantum lengthens the first segment or shortens the second. The correction is limited by a programmable jump width, and only one correction is applied in each bit. Two 8-bit configuration registers can be read at any time. They can be written only while the controller is in initialisation mode, and in that mode the timing engine is held idle.

The outputs are a one-cycle sample strobe that carries the received bit value, and a one-cycle bit-start strobe for the transmit path.

Top module: `can_bit_timer`

## Requirements
- R1: While reset is asserted, both configuration registers read 0x00 and `sample_vld` and `bit_start` are low.
- R2: A configuration write is applied only when `init_req` and `init_ack` are both high. Otherwise the register keeps its value. `cfg_sel`=0 selects the rate register and `cfg_sel`=1 selects the timing register.
- R3: A time quantum lasts P+1 module clocks, where P is the rate register bits 5:0 (0..63).
- R4: With no resynchronisation, a bit lasts 1 + (T1+1) + (T2+1) quanta. T1 is timing register bits 3:0 and T2 is bits 6:4. `bit_start` pulses for one cycle right after the last quantum of every bit.
- R5: `sample_vld` pulses for one cycle right after the clock edge that ends the first segment. When timing bit 7 is 0, `sample_bit` equals the value of `rx_in` at that edge.
- R6: When timing bit 7 is 1, `sample_bit` is the majority of `rx_in` at the sample edge and at the two preceding quantum-ending edges.
- R7: A falling edge of `rx_in` in quantum k of the first segment (k from 0) lengthens that segment by min(k+1, J) quanta. J = rate register bits 7:6 plus one (1..4).
- R8: A falling edge in quantum k of the second segment (length L2) shortens that segment by min(L2-1-k, J) quanta.
- R9: Rising edges, falling edges in the synchronisation quantum, and any falling edge after the first correction in the same bit change no timing.
- R10: While in initialisation mode, no strobe is produced. On leaving it, a bit begins with its synchronisation quantum at the first clock edge that is out of initialisation mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Initialisation mode requested |
| init_ack | input | 1 | Initialisation mode acknowledged |
| cfg_wr | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | Register select: 0 rate, 1 timing |
| cfg_wdata | input | 8 | Configuration write data |
| rate_reg_q | output | 8 | Rate register: jump width code [7:6], prescaler [5:0] |
| timing_reg_q | output | 8 | Timing register: triple sample [7], T2 [6:4], T1 [3:0] |
| rx_in | input | 1 | Receive line, 1 recessive, 0 dominant |
| sample_vld | output | 1 | One-cycle strobe: sampled bit available |
| sample_bit | output | 1 | Received bit value |
| bit_start | output | 1 | One-cycle strobe: new bit time begins |

## Verification
A falling edge can arrive in the same clock cycle as the quantum boundary that would otherwise end a segment. In that cycle the correction must already be applied to the end-of-segment decision, so the sample point or bit end moves in that same cycle. With a prescaler of zero every cycle is a quantum boundary, and random line toggling then forces this coincidence often. Directed edges are also placed in chosen quanta. The bench judges the outcome against its own quantum-position model, which applies the correction before it tests for the segment end, and also against measured bit lengths.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  parameter int PRE_W = 6;
  parameter int SJW_W = 2;
  parameter int TS1_W = 4;
  parameter int TS2_W = 3;
  parameter int REG_W = 8;

  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_SEG1 = 2'd1,
    PH_SEG2 = 2'd2
  } bt_phase_e;

  typedef struct packed {
    logic             triple;
    logic [TS2_W-1:0] ts2;
    logic [TS1_W-1:0] ts1;
    logic [SJW_W-1:0] sjw;
    logic [PRE_W-1:0] brp;
  } bt_cfg_t;

endpackage

// File: rtl/can_bt_regs.sv
module can_bt_regs
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_req,
  input  logic             init_ack,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] rate_q,
  output logic [REG_W-1:0] timing_q,
  output logic             init_on,
  output bt_cfg_t          cfg
);

  logic [REG_W-1:0] rate_d;
  logic [REG_W-1:0] timing_d;
  logic             wr_rate_en;
  logic             wr_timing_en;

  assign init_on      = init_req & init_ack;
  assign wr_rate_en   = cfg_wr & init_on & ~cfg_sel;
  assign wr_timing_en = cfg_wr & init_on &  cfg_sel;

  always_comb begin
    rate_d   = rate_q;
    timing_d = timing_q;
    if (wr_rate_en)   rate_d   = cfg_wdata;
    if (wr_timing_en) timing_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q   <= '0;
      timing_q <= '0;
    end else begin
      rate_q   <= rate_d;
      timing_q <= timing_d;
    end
  end

  // field placement: timing bit 7 mode, 6:4 second segment, 3:0 first segment
  assign cfg.brp    = rate_q[PRE_W-1:0];
  assign cfg.sjw    = rate_q[REG_W-1 -: SJW_W];
  assign cfg.triple = timing_q[REG_W-1];
  assign cfg.ts2    = timing_q[TS1_W +: TS2_W];
  assign cfg.ts1    = timing_q[TS1_W-1:0];

endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] div,
  output logic         tq_tick
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  assign tq_tick = ~clear & (cnt_q == div);

  always_comb begin
    if (clear || tq_tick) cnt_d = '0;
    else                  cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int T1W = 4,
  parameter int T2W = 3,
  parameter int JW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           tq_tick,
  input  logic           edge_fall,
  input  logic [T1W-1:0] ts1,
  input  logic [T2W-1:0] ts2,
  input  logic [JW-1:0]  sjw,
  output logic           sample_tick,
  output logic           bit_end
);

  localparam int QW = ((T1W > T2W) ? T1W : T2W) + 2;

  bt_phase_e       ph_q, ph_d;
  logic [QW-1:0]   q_q, q_d;
  logic [QW-1:0]   len1_q, len1_d;
  logic [QW-1:0]   len2_q, len2_d;
  logic            rs_q, rs_d;

  logic [QW-1:0]   jump_v;
  logic [QW-1:0]   base1;
  logic [QW-1:0]   base2;
  logic [QW-1:0]   err1;
  logic [QW-1:0]   rem2;
  logic [QW-1:0]   adj1;
  logic [QW-1:0]   adj2;
  logic [QW-1:0]   len1_n;
  logic [QW-1:0]   len2_n;
  logic            rs_go;
  logic            last1;
  logic            last2;

  assign jump_v = QW'(sjw) + QW'(1);
  assign base1  = QW'(ts1) + QW'(1);
  assign base2  = QW'(ts2) + QW'(1);
  assign err1   = q_q + QW'(1);
  assign rem2   = len2_q - q_q - QW'(1);

  // correction is folded into the same-cycle end-of-segment decision
  always_comb begin
    rs_go  = edge_fall & ~rs_q & ~clear & (ph_q != PH_SYNC);
    adj1   = (err1 < jump_v) ? err1 : jump_v;
    adj2   = (rem2 < jump_v) ? rem2 : jump_v;
    len1_n = (rs_go && ph_q == PH_SEG1) ? (len1_q + adj1) : len1_q;
    len2_n = (rs_go && ph_q == PH_SEG2) ? (len2_q - adj2) : len2_q;
    last1  = (q_q == (len1_n - QW'(1)));
    last2  = (q_q == (len2_n - QW'(1)));
  end

  assign sample_tick = tq_tick & (ph_q == PH_SEG1) & last1;
  assign bit_end     = tq_tick & (ph_q == PH_SEG2) & last2;

  always_comb begin
    ph_d   = ph_q;
    q_d    = q_q;
    len1_d = len1_q;
    len2_d = len2_q;
    rs_d   = rs_q;
    if (clear) begin
      ph_d   = PH_SYNC;
      q_d    = '0;
      len1_d = base1;
      len2_d = base2;
      rs_d   = 1'b0;
    end else begin
      len1_d = len1_n;
      len2_d = len2_n;
      if (rs_go) rs_d = 1'b1;
      if (tq_tick) begin
        unique case (ph_q)
          PH_SYNC: begin
            ph_d = PH_SEG1;
            q_d  = '0;
          end
          PH_SEG1: begin
            if (last1) begin
              ph_d = PH_SEG2;
              q_d  = '0;
            end else begin
              q_d = q_q + QW'(1);
            end
          end
          PH_SEG2: begin
            if (last2) begin
              ph_d   = PH_SYNC;
              q_d    = '0;
              len1_d = base1;
              len2_d = base2;
              rs_d   = 1'b0;
            end else begin
              q_d = q_q + QW'(1);
            end
          end
          default: begin
            ph_d = PH_SYNC;
            q_d  = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_SYNC;
      q_q    <= '0;
      len1_q <= QW'(1);
      len2_q <= QW'(1);
      rs_q   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      q_q    <= q_d;
      len1_q <= len1_d;
      len2_q <= len2_d;
      rs_q   <= rs_d;
    end
  end

endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler #(
  parameter int HIST = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tq_tick,
  input  logic sample_tick,
  input  logic triple,
  input  logic rx,
  output logic sample_vld,
  output logic sample_bit
);

  logic [HIST-1:0] hist_q, hist_d;
  logic            vld_d;
  logic            bit_d;
  logic            vote;

  assign vote = (hist_q[1] & hist_q[0]) | (hist_q[1] & rx) | (hist_q[0] & rx);

  always_comb begin
    hist_d = hist_q;
    if (tq_tick) hist_d = {hist_q[HIST-2:0], rx};
    vld_d = sample_tick & ~clear;
    bit_d = sample_bit;
    if (sample_tick) bit_d = triple ? vote : rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q     <= '1;
      sample_vld <= 1'b0;
      sample_bit <= 1'b1;
    end else begin
      hist_q     <= hist_d;
      sample_vld <= vld_d;
      sample_bit <= bit_d;
    end
  end

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_req,
  input  logic             init_ack,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] rate_reg_q,
  output logic [REG_W-1:0] timing_reg_q,
  input  logic             rx_in,
  output logic             sample_vld,
  output logic             sample_bit,
  output logic             bit_start
);

  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  bt_cfg_t    cfg;
  logic       init_on;
  logic       tq_tick;
  logic       rx_prev_q;
  logic       edge_fall;
  logic       sample_tick;
  logic       bit_end;
  logic       bit_start_d;

  // reset asserts at once, leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  can_bt_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .init_req  (init_req),
    .init_ack  (init_ack),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .rate_q    (rate_reg_q),
    .timing_q  (timing_reg_q),
    .init_on   (init_on),
    .cfg       (cfg)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rx_prev_q <= 1'b1;
    else          rx_prev_q <= rx_in;
  end
  assign edge_fall = rx_prev_q & ~rx_in;

  can_bt_prescaler #(.W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clear   (init_on),
    .div     (cfg.brp),
    .tq_tick (tq_tick)
  );

  can_bt_seq #(.T1W(TS1_W), .T2W(TS2_W), .JW(SJW_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .clear       (init_on),
    .tq_tick     (tq_tick),
    .edge_fall   (edge_fall),
    .ts1         (cfg.ts1),
    .ts2         (cfg.ts2),
    .sjw         (cfg.sjw),
    .sample_tick (sample_tick),
    .bit_end     (bit_end)
  );

  can_bt_sampler #(.HIST(2)) u_smp (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .clear       (init_on),
    .tq_tick     (tq_tick),
    .sample_tick (sample_tick),
    .triple      (cfg.triple),
    .rx          (rx_in),
    .sample_vld  (sample_vld),
    .sample_bit  (sample_bit)
  );

  assign bit_start_d = bit_end & ~init_on;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) bit_start <= 1'b0;
    else          bit_start <= bit_start_d;
  end

endmodule

// File: rtl/can_bt_checker.sv
module can_bt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       init_req,
  input logic       init_ack,
  input logic [7:0] rate_reg_q,
  input logic [7:0] timing_reg_q,
  input logic       sample_vld,
  input logic       bit_start
);

  // R1: strobes quiet while reset is held
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!sample_vld && !bit_start));

  // R2: registers frozen outside initialisation mode
  a_r2_hold_outside_init: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_req && init_ack) |=> ($stable(rate_reg_q) && $stable(timing_reg_q)));

  // R5: sample strobe lasts one cycle
  a_r5_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> !sample_vld);

  // R4: bit-start strobe lasts one cycle and never meets the sample strobe
  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |=> !bit_start);

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_vld, bit_start}));

  // R10: engine idle during initialisation mode
  a_r10_idle_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && init_ack) |=> (!sample_vld && !bit_start));

endmodule

bind can_bit_timer can_bt_checker i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .init_req     (init_req),
  .init_ack     (init_ack),
  .rate_reg_q   (rate_reg_q),
  .timing_reg_q (timing_reg_q),
  .sample_vld   (sample_vld),
  .bit_start    (bit_start)
);

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;

  logic       clk;
  logic       rst_n;
  logic       init_req;
  logic       init_ack;
  logic       cfg_wr;
  logic       cfg_sel;
  logic [7:0] cfg_wdata;
  logic [7:0] rate_reg_q;
  logic [7:0] timing_reg_q;
  logic       rx_in;
  logic       sample_vld;
  logic       sample_bit;
  logic       bit_start;

  int  vec_cnt;
  int  err_cnt;
  bit  finished;

  // bench model state
  logic [7:0] sh_rate;
  logic [7:0] sh_tim;
  int  m_pc, m_pos, m_l1, m_l2;
  bit  m_done, m_prev;
  bit  [1:0] m_h;
  int  cyc;
  int  last_bs_cyc;
  int  bs_gap;
  bit  saw_bs;

  can_bit_timer i_can_bit_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_req     (init_req),
    .init_ack     (init_ack),
    .cfg_wr       (cfg_wr),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .rate_reg_q   (rate_reg_q),
    .timing_reg_q (timing_reg_q),
    .rx_in        (rx_in),
    .sample_vld   (sample_vld),
    .sample_bit   (sample_bit),
    .bit_start    (bit_start)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic bit maj3(input bit a, input bit b, input bit c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one clock: drive at falling edge, predict, compare after rising edge
  task automatic step(input bit rx_v, input bit ini, input bit wr, input bit sel,
                      input logic [7:0] wd, input string tag);
    bit exp_v, exp_s, exp_b, tick, edg;
    int brp, jw, l1b, l2b, rem;
    @(negedge clk);
    rx_in = rx_v; init_req = ini; init_ack = ini;
    cfg_wr = wr; cfg_sel = sel; cfg_wdata = wd;
    brp = int'(sh_rate[5:0]);
    jw  = int'(sh_rate[7:6]) + 1;
    l1b = int'(sh_tim[3:0]) + 1;
    l2b = int'(sh_tim[6:4]) + 1;
    exp_v = 0; exp_s = 0; exp_b = 0;
    if (ini) begin
      m_pc = 0; m_pos = 0; m_l1 = l1b; m_l2 = l2b; m_done = 0;
      if (wr) begin
        if (sel) sh_tim = wd;
        else     sh_rate = wd;
      end
    end else begin
      tick = (m_pc == brp);
      edg  = m_prev && !rx_v;
      if (edg && !m_done && m_pos != 0) begin
        if (m_pos <= m_l1) m_l1 += imin(m_pos, jw);
        else begin
          rem  = m_l1 + m_l2 - m_pos;
          m_l2 -= imin(rem, jw);
        end
        m_done = 1;
      end
      if (tick) begin
        if (m_pos == m_l1) begin
          exp_v = 1;
          exp_b = sh_tim[7] ? maj3(m_h[1], m_h[0], rx_v) : rx_v;
        end
        if (m_pos == m_l1 + m_l2) begin
          exp_s = 1; m_pos = 0; m_l1 = l1b; m_l2 = l2b; m_done = 0;
        end else m_pos++;
        m_h = {m_h[0], rx_v};
        m_pc = 0;
      end else m_pc++;
    end
    m_prev = rx_v;
    @(posedge clk);
    #1;
    cyc++;
    check(sample_vld === exp_v, tag, "sample_vld", int'(sample_vld), int'(exp_v));
    if (exp_v)
      check(sample_bit === exp_b, tag, "sample_bit", int'(sample_bit), int'(exp_b));
    check(bit_start === exp_s, tag, "bit_start", int'(bit_start), int'(exp_s));
    if (rate_reg_q !== sh_rate || timing_reg_q !== sh_tim)
      check(0, "R2", "register readback", int'({rate_reg_q, timing_reg_q}),
            int'({sh_rate, sh_tim}));
    saw_bs = (bit_start === 1'b1);
    if (saw_bs) begin
      bs_gap = cyc - last_bs_cyc;
      last_bs_cyc = cyc;
    end
  endtask

  task automatic idle(input bit rx_v, input string tag);
    step(rx_v, 0, 0, 0, 8'h00, tag);
  endtask

  task automatic configure(input logic [7:0] rate, input logic [7:0] tim, input string tag);
    step(1, 1, 0, 0, 8'h00, tag);
    step(1, 1, 1, 0, rate, tag);
    step(1, 1, 1, 1, tim, tag);
    step(1, 1, 0, 0, 8'h00, tag);
  endtask

  task automatic wait_bs(input bit rx_v, input string tag);
    for (int i = 0; i < 3000; i++) begin
      idle(rx_v, tag);
      if (saw_bs) break;
    end
  endtask

  initial begin
    finished = 0;
    #3000000;
    if (!finished) begin
      err_cnt++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    vec_cnt = 0; err_cnt = 0; cyc = 0; last_bs_cyc = 0; bs_gap = 0; saw_bs = 0;
    sh_rate = 8'h00; sh_tim = 8'h00;
    m_pc = 0; m_pos = 0; m_l1 = 1; m_l2 = 1; m_done = 0; m_prev = 1; m_h = 2'b11;
    rst_n = 0; rx_in = 1; init_req = 0; init_ack = 0;
    cfg_wr = 0; cfg_sel = 0; cfg_wdata = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(rate_reg_q === 8'h00, "R1", "rate reg in reset", int'(rate_reg_q), 0);
    check(timing_reg_q === 8'h00, "R1", "timing reg in reset", int'(timing_reg_q), 0);
    check(sample_vld === 1'b0, "R1", "sample_vld in reset", int'(sample_vld), 0);
    check(bit_start === 1'b0, "R1", "bit_start in reset", int'(bit_start), 0);
    rst_n = 1;
    repeat (4) @(posedge clk);

    // R3 / R4: quantum of 3 clocks, bit of 1+4+3 quanta
    configure(8'h02, 8'h23, "R2");
    wait_bs(1, "R4");
    wait_bs(1, "R4");
    check(bs_gap == 24, "R3", "bit period in clocks", bs_gap, 24);
    for (int i = 0; i < 120; i++) idle(($urandom % 5) != 0, "R5");

    // R2: writes outside initialisation mode are dropped
    step(1, 0, 1, 0, 8'hFF, "R2");
    step(1, 0, 1, 1, 8'hFF, "R2");
    check(rate_reg_q === 8'h02, "R2", "rate reg after blocked write", int'(rate_reg_q), 2);
    check(timing_reg_q === 8'h23, "R2", "timing reg after blocked write", int'(timing_reg_q), 8'h23);

    // R10: idle in init, fresh bit on release
    for (int i = 0; i < 30; i++) step($urandom % 2, 1, 0, 0, 8'h00, "R10");
    begin
      int n;
      n = 0;
      for (int i = 0; i < 200; i++) begin
        idle(1, "R10");
        n++;
        if (saw_bs) break;
      end
      check(n == 24, "R10", "clocks from release to first bit_start", n, 24);
    end

    // R7: edge in first-segment quantum 2, jump 4 -> +3
    configure(8'hC0, 8'h37, "R2");
    wait_bs(1, "R7");
    repeat (3) idle(1, "R7");
    wait_bs(0, "R7");
    check(bs_gap == 16, "R7", "lengthened bit", bs_gap, 16);

    // R8: edge in second-segment quantum 1 of 4 -> -2
    wait_bs(1, "R8");
    repeat (10) idle(1, "R8");
    wait_bs(0, "R8");
    check(bs_gap == 11, "R8", "shortened bit", bs_gap, 11);

    // R7: jump width 1 clips the correction
    configure(8'h00, 8'h37, "R2");
    wait_bs(1, "R7");
    repeat (5) idle(1, "R7");
    wait_bs(0, "R7");
    check(bs_gap == 14, "R7", "clipped lengthening", bs_gap, 14);

    // R9: edge in sync ignored; second edge in a bit ignored
    configure(8'hC0, 8'h37, "R2");
    wait_bs(1, "R9");
    idle(0, "R9");
    wait_bs(0, "R9");
    check(bs_gap == 13, "R9", "edge in sync quantum", bs_gap, 13);
    wait_bs(1, "R9");
    check(bs_gap == 13, "R9", "rising edge no effect", bs_gap, 13);
    repeat (3) idle(1, "R9");
    idle(0, "R9");
    idle(1, "R9");
    wait_bs(0, "R9");
    check(bs_gap == 16, "R9", "one correction per bit", bs_gap, 16);

    // R6: triple sampling with every cycle a quantum boundary
    configure(8'h40, 8'hB2, "R2");
    for (int i = 0; i < 300; i++) idle(($urandom % 3) != 0, "R6");

    // random configurations and line activity
    for (int it = 0; it < 24; it++) begin
      logic [7:0] rt, tm;
      bit lvl;
      rt = {2'($urandom % 4), 3'b000, 3'($urandom % 8)};
      tm = 8'($urandom % 256);
      configure(rt, tm, "R2");
      lvl = 1;
      for (int i = 0; i < 260; i++) begin
        if (($urandom % 6) == 0) lvl = ~lvl;
        idle(lvl, tm[7] ? "R6" : "R5");
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

endmodule